// File: doc/BRIEF.md
# Exception Entry Stacking Sequencer

This block carries out the hardware side of taking an interrupt on a small 32-bit processor. It accepts an entry request that carries a vector number and the vector table base, then waits until the core reports that the instruction in flight has retired. At that point it captures the architectural context: the argument registers, R12, the link register, the program counter, the status word and the stack pointer. If the floating-point unit is marked active, it also captures sixteen FP registers and the FP status word.

The captured context is pushed, one word per handshake, through a 32-bit memory write port onto a full-descending stack. The frame is eight words for a plain entry and twenty-six words when FP state is included. Once the last write has been acknowledged, the sequencer reads the handler address from the vector table through a read port. It then publishes the new stack pointer, a return token for the link register, a status word whose low byte names the serviced vector, and the handler address as the new PC. A one-cycle done pulse marks the moment these four values change. Unstacking on return is handled elsewhere.

Top module: `exc_entry_seq`

## Requirements
- R1: After reset, busy_o, done_o, wr_valid_o and rd_valid_o are 0, and sp_o, lr_o, pc_o and psr_o are all zero.
- R2: An accepted request (entry_req_i high while idle) makes busy_o high, but no memory access starts until retire_i has been seen high; context inputs are captured in that retire cycle.
- R3: For a plain entry the new stack pointer is sp_i minus 32, and eight words are written at ascending addresses starting there, in the order R0, R1, R2, R3, R12, LR, PC, status word.
- R4: With fp_active_i high the new stack pointer is sp_i minus 104 and twenty-six words are written: the eight of R3, then FP registers 0 to 15 (register k is fpr_i[32k+31:32k]), then fpscr_i, then a zero word.
- R5: While wr_valid_o or rd_valid_o is high and the matching ready is low, the valid, address and data stay unchanged into the next cycle.
- R6: lr_o is loaded with a token whose bits [31:5] are ones, bit 4 is 1 for a plain frame and 0 for an FP frame, bit 3 is thread_mode_i, bit 2 is thread_mode_i AND proc_stack_i, bit 1 is 0 and bit 0 is 1.
- R7: psr_o is loaded with bits [31:8] of the captured status word and the vector number in bits [7:0].
- R8: The vector read address is vec_base_i plus four times the vector number; the read starts only after the last stack write is acknowledged, and pc_o takes the read data.
- R9: done_o is high for exactly one cycle, in the same cycle that sp_o, lr_o, psr_o and pc_o first show their new values; these outputs do not change at any other time.
- R10: entry_req_i raised while busy_o is high is ignored: the running entry keeps its vector and no second entry follows.

Ports table follows in port-list order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| entry_req_i | input | 1 | Exception entry request |
| retire_i | input | 1 | Instruction in flight has completed |
| vec_num_i | input | 8 | Vector number of the exception |
| vec_base_i | input | 32 | Vector table base address |
| fp_active_i | input | 1 | FP context must be saved |
| thread_mode_i | input | 1 | Core was in thread mode |
| proc_stack_i | input | 1 | Core was using the process stack |
| r0_i | input | 32 | R0 value |
| r1_i | input | 32 | R1 value |
| r2_i | input | 32 | R2 value |
| r3_i | input | 32 | R3 value |
| r12_i | input | 32 | R12 value |
| lr_i | input | 32 | Link register value |
| pc_i | input | 32 | Return address |
| psr_i | input | 32 | Status word |
| sp_i | input | 32 | Current stack pointer |
| fpr_i | input | 512 | FP registers 0 to 15, register k at bits [32k+31:32k] |
| fpscr_i | input | 32 | FP status word |
| wr_valid_o | output | 1 | Stack write request |
| wr_addr_o | output | 32 | Stack write address |
| wr_data_o | output | 32 | Stack write data |
| wr_ready_i | input | 1 | Stack write accepted |
| rd_valid_o | output | 1 | Vector read request |
| rd_addr_o | output | 32 | Vector read address |
| rd_ready_i | input | 1 | Vector read accepted, data valid |
| rd_data_i | input | 32 | Vector read data |
| busy_o | output | 1 | Entry sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |
| sp_o | output | 32 | New stack pointer |
| lr_o | output | 32 | Return token |
| pc_o | output | 32 | Handler address |
| psr_o | output | 32 | Status word with vector number |

## Verification
Entries are run with plain and FP frames, each in handler mode and in thread mode on both stacks. This separates the frame-length and stack-pointer arithmetic from the three mode bits of the return token. Each frame shape is run once with memory that is always ready and once with memory that stalls in a repeating pattern; the stalled runs show whether address and data are held and the word order survives back-pressure. Vector numbers 0 and 255 and different table bases test the read address. A second request injected mid-sequence with a different vector shows whether a busy sequencer leaks the new vector or starts a second entry.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;

    // Sequencer phases
    typedef enum logic [1:0] {
        SQ_IDLE  = 2'd0,
        SQ_WAIT  = 2'd1,
        SQ_PUSH  = 2'd2,
        SQ_FETCH = 2'd3
    } seq_state_e;

    // Words in the plain context frame
    localparam int unsigned BASIC_WORDS = 8;

    // Words added beyond the FP registers: status word and one reserved slot
    localparam int unsigned FP_TAIL_WORDS = 2;

endpackage

// File: rtl/exc_frame_build.sv
module exc_frame_build
    import exc_entry_pkg::*;
#(
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned FP_REGS = 16,
    localparam int unsigned FRAME_MAX = BASIC_WORDS + FP_REGS + FP_TAIL_WORDS
) (
    input  logic [DATA_W-1:0]         r0_i,
    input  logic [DATA_W-1:0]         r1_i,
    input  logic [DATA_W-1:0]         r2_i,
    input  logic [DATA_W-1:0]         r3_i,
    input  logic [DATA_W-1:0]         r12_i,
    input  logic [DATA_W-1:0]         lr_i,
    input  logic [DATA_W-1:0]         pc_i,
    input  logic [DATA_W-1:0]         psr_i,
    input  logic [FP_REGS*DATA_W-1:0] fpr_i,
    input  logic [DATA_W-1:0]         fpscr_i,
    output logic [FRAME_MAX-1:0][DATA_W-1:0] frame_o
);

    // Frame slots in ascending address order
    always_comb begin
        frame_o[0] = r0_i;
        frame_o[1] = r1_i;
        frame_o[2] = r2_i;
        frame_o[3] = r3_i;
        frame_o[4] = r12_i;
        frame_o[5] = lr_i;
        frame_o[6] = pc_i;
        frame_o[7] = psr_i;
        for (int k = 0; k < FP_REGS; k++) begin
            frame_o[BASIC_WORDS + k] = fpr_i[k*DATA_W +: DATA_W];
        end
        frame_o[BASIC_WORDS + FP_REGS]     = fpscr_i;
        frame_o[BASIC_WORDS + FP_REGS + 1] = '0;
    end

endmodule

// File: rtl/exc_ret_token.sv
module exc_ret_token #(
    parameter int unsigned DATA_W = 32
) (
    input  logic              fp_active_i,
    input  logic              thread_mode_i,
    input  logic              proc_stack_i,
    output logic [DATA_W-1:0] token_o
);

    // Upper bits fixed high, bit0 fixed high, bits 4:1 describe the return path
    always_comb begin
        token_o = {{(DATA_W-5){1'b1}},
                   ~fp_active_i,
                   thread_mode_i,
                   thread_mode_i & proc_stack_i,
                   1'b0,
                   1'b1};
    end

endmodule

// File: rtl/exc_addr_calc.sv
module exc_addr_calc
    import exc_entry_pkg::*;
#(
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned VEC_W   = 8,
    parameter int unsigned FP_REGS = 16,
    localparam int unsigned FRAME_MAX   = BASIC_WORDS + FP_REGS + FP_TAIL_WORDS,
    localparam int unsigned BASIC_BYTES = 4 * BASIC_WORDS,
    localparam int unsigned FULL_BYTES  = 4 * FRAME_MAX
) (
    input  logic [DATA_W-1:0] sp_i,
    input  logic              fp_active_i,
    input  logic [DATA_W-1:0] vec_base_i,
    input  logic [VEC_W-1:0]  vec_num_i,
    output logic [DATA_W-1:0] new_sp_o,
    output logic [DATA_W-1:0] vec_addr_o
);

    logic [DATA_W-1:0] frame_bytes;

    always_comb begin
        frame_bytes = fp_active_i ? DATA_W'(FULL_BYTES) : DATA_W'(BASIC_BYTES);
        new_sp_o    = sp_i - frame_bytes;
        vec_addr_o  = vec_base_i + DATA_W'({vec_num_i, 2'b00});
    end

endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
    import exc_entry_pkg::*;
#(
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned VEC_W   = 8,
    parameter int unsigned FP_REGS = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      entry_req_i,
    input  logic                      retire_i,
    input  logic [VEC_W-1:0]          vec_num_i,
    input  logic [DATA_W-1:0]         vec_base_i,
    input  logic                      fp_active_i,
    input  logic                      thread_mode_i,
    input  logic                      proc_stack_i,
    input  logic [DATA_W-1:0]         r0_i,
    input  logic [DATA_W-1:0]         r1_i,
    input  logic [DATA_W-1:0]         r2_i,
    input  logic [DATA_W-1:0]         r3_i,
    input  logic [DATA_W-1:0]         r12_i,
    input  logic [DATA_W-1:0]         lr_i,
    input  logic [DATA_W-1:0]         pc_i,
    input  logic [DATA_W-1:0]         psr_i,
    input  logic [DATA_W-1:0]         sp_i,
    input  logic [FP_REGS*DATA_W-1:0] fpr_i,
    input  logic [DATA_W-1:0]         fpscr_i,
    output logic                      wr_valid_o,
    output logic [DATA_W-1:0]         wr_addr_o,
    output logic [DATA_W-1:0]         wr_data_o,
    input  logic                      wr_ready_i,
    output logic                      rd_valid_o,
    output logic [DATA_W-1:0]         rd_addr_o,
    input  logic                      rd_ready_i,
    input  logic [DATA_W-1:0]         rd_data_i,
    output logic                      busy_o,
    output logic                      done_o,
    output logic [DATA_W-1:0]         sp_o,
    output logic [DATA_W-1:0]         lr_o,
    output logic [DATA_W-1:0]         pc_o,
    output logic [DATA_W-1:0]         psr_o
);

    localparam int unsigned FRAME_MAX = BASIC_WORDS + FP_REGS + FP_TAIL_WORDS;
    localparam int unsigned IDX_W     = $clog2(FRAME_MAX);
    localparam logic [IDX_W-1:0] LAST_BASIC = IDX_W'(BASIC_WORDS - 1);
    localparam logic [IDX_W-1:0] LAST_FULL  = IDX_W'(FRAME_MAX - 1);

    typedef struct packed {
        seq_state_e                      st;
        logic [IDX_W-1:0]                idx;
        logic [VEC_W-1:0]                vec;
        logic [DATA_W-1:0]               vbase;
        logic [FRAME_MAX-1:0][DATA_W-1:0] frame;
        logic [DATA_W-1:0]               nsp;
        logic [DATA_W-1:0]               token;
        logic [DATA_W-1:0]               psr_cap;
        logic                            fp;
        logic [DATA_W-1:0]               sp_out;
        logic [DATA_W-1:0]               lr_out;
        logic [DATA_W-1:0]               pc_out;
        logic [DATA_W-1:0]               psr_out;
        logic                            done;
    } seq_t;

    seq_t seq_d, seq_q;

    logic [FRAME_MAX-1:0][DATA_W-1:0] frame_w;
    logic [DATA_W-1:0]                token_w;
    logic [DATA_W-1:0]                nsp_w;
    logic [DATA_W-1:0]                vaddr_w;
    logic [IDX_W-1:0]                 last_idx;

    exc_frame_build #(
        .DATA_W  (DATA_W),
        .FP_REGS (FP_REGS)
    ) frame_i (
        .r0_i    (r0_i),
        .r1_i    (r1_i),
        .r2_i    (r2_i),
        .r3_i    (r3_i),
        .r12_i   (r12_i),
        .lr_i    (lr_i),
        .pc_i    (pc_i),
        .psr_i   (psr_i),
        .fpr_i   (fpr_i),
        .fpscr_i (fpscr_i),
        .frame_o (frame_w)
    );

    exc_ret_token #(
        .DATA_W (DATA_W)
    ) token_i (
        .fp_active_i   (fp_active_i),
        .thread_mode_i (thread_mode_i),
        .proc_stack_i  (proc_stack_i),
        .token_o       (token_w)
    );

    // Stack arithmetic uses live inputs (captured at retire);
    // the vector address uses values latched at acceptance.
    exc_addr_calc #(
        .DATA_W  (DATA_W),
        .VEC_W   (VEC_W),
        .FP_REGS (FP_REGS)
    ) addr_i (
        .sp_i        (sp_i),
        .fp_active_i (fp_active_i),
        .vec_base_i  (seq_q.vbase),
        .vec_num_i   (seq_q.vec),
        .new_sp_o    (nsp_w),
        .vec_addr_o  (vaddr_w)
    );

    assign last_idx = seq_q.fp ? LAST_FULL : LAST_BASIC;

    always_comb begin
        seq_d      = seq_q;
        seq_d.done = 1'b0;
        case (seq_q.st)
            SQ_IDLE: begin
                if (entry_req_i) begin
                    seq_d.st    = SQ_WAIT;
                    seq_d.vec   = vec_num_i;
                    seq_d.vbase = vec_base_i;
                end
            end
            SQ_WAIT: begin
                if (retire_i) begin
                    seq_d.st      = SQ_PUSH;
                    seq_d.idx     = '0;
                    seq_d.frame   = frame_w;
                    seq_d.nsp     = nsp_w;
                    seq_d.token   = token_w;
                    seq_d.psr_cap = psr_i;
                    seq_d.fp      = fp_active_i;
                end
            end
            SQ_PUSH: begin
                if (wr_ready_i) begin
                    if (seq_q.idx == last_idx) begin
                        seq_d.st = SQ_FETCH;
                    end else begin
                        seq_d.idx = seq_q.idx + 1'b1;
                    end
                end
            end
            SQ_FETCH: begin
                if (rd_ready_i) begin
                    seq_d.st      = SQ_IDLE;
                    seq_d.pc_out  = rd_data_i;
                    seq_d.lr_out  = seq_q.token;
                    seq_d.sp_out  = seq_q.nsp;
                    seq_d.psr_out = {seq_q.psr_cap[DATA_W-1:VEC_W], seq_q.vec};
                    seq_d.done    = 1'b1;
                end
            end
            default: seq_d.st = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign wr_valid_o = (seq_q.st == SQ_PUSH);
    assign wr_addr_o  = seq_q.nsp + DATA_W'({seq_q.idx, 2'b00});
    assign wr_data_o  = seq_q.frame[seq_q.idx];
    assign rd_valid_o = (seq_q.st == SQ_FETCH);
    assign rd_addr_o  = vaddr_w;
    assign busy_o     = (seq_q.st != SQ_IDLE);
    assign done_o     = seq_q.done;
    assign sp_o       = seq_q.sp_out;
    assign lr_o       = seq_q.lr_out;
    assign pc_o       = seq_q.pc_out;
    assign psr_o      = seq_q.psr_out;

endmodule

// File: rtl/exc_entry_chk.sv
module exc_entry_chk #(
    parameter int unsigned DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_valid_o,
    input logic              wr_ready_i,
    input logic [DATA_W-1:0] wr_addr_o,
    input logic [DATA_W-1:0] wr_data_o,
    input logic              rd_valid_o,
    input logic              rd_ready_i,
    input logic [DATA_W-1:0] rd_addr_o,
    input logic              busy_o,
    input logic              done_o,
    input logic [DATA_W-1:0] sp_o,
    input logic [DATA_W-1:0] lr_o,
    input logic [DATA_W-1:0] pc_o
);

    a_r5_wr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid_o && !wr_ready_i) |=> (wr_valid_o && $stable(wr_addr_o) && $stable(wr_data_o)));

    a_r5_rd_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid_o && !rd_ready_i) |=> (rd_valid_o && $stable(rd_addr_o)));

    a_r3_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid_o && wr_ready_i) |=> (!wr_valid_o || (wr_addr_o == $past(wr_addr_o) + DATA_W'(4))));

    a_r8_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_valid_o && rd_valid_o));

    a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (!wr_valid_o && !rd_valid_o));

    a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    a_r9_hold_outputs: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> ($stable(sp_o) && $stable(lr_o) && $stable(pc_o)));

    a_r6_token_form: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> ((&lr_o[DATA_W-1:5]) && lr_o[0] && !lr_o[1]));

endmodule

bind exc_entry_seq exc_entry_chk #(.DATA_W(DATA_W)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_valid_o (wr_valid_o),
    .wr_ready_i (wr_ready_i),
    .wr_addr_o  (wr_addr_o),
    .wr_data_o  (wr_data_o),
    .rd_valid_o (rd_valid_o),
    .rd_ready_i (rd_ready_i),
    .rd_addr_o  (rd_addr_o),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .sp_o       (sp_o),
    .lr_o       (lr_o),
    .pc_o       (pc_o)
);

// File: tb/exc_entry_seq_tb_top.sv
module exc_entry_seq_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int FP_REGS    = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         entry_req = 1'b0;
    logic         retire = 1'b0;
    logic [7:0]   vec_num = '0;
    logic [31:0]  vec_base = '0;
    logic         fp_active = 1'b0;
    logic         thread_mode = 1'b0;
    logic         proc_stack = 1'b0;
    logic [31:0]  r0 = '0, r1 = '0, r2 = '0, r3 = '0, r12 = '0;
    logic [31:0]  lr = '0, pc = '0, psr = '0, sp = '0, fpscr = '0;
    logic [FP_REGS*32-1:0] fpr = '0;
    logic         wr_valid, rd_valid, busy, done;
    logic [31:0]  wr_addr, wr_data, rd_addr, rd_data;
    logic [31:0]  sp_out, lr_out, pc_out, psr_out;
    logic         wr_ready = 1'b0;
    logic         rd_ready = 1'b0;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int stall_mode = 0;
    logic [31:0] exp_vaddr = '0;
    logic [63:0] exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    // Vector table model: entry content derived from its address
    assign rd_data = {rd_addr[15:0], 16'hC0DE};

    exc_entry_seq dut_i (
        .clk(clk), .rst_n(rst_n), .entry_req_i(entry_req), .retire_i(retire),
        .vec_num_i(vec_num), .vec_base_i(vec_base), .fp_active_i(fp_active),
        .thread_mode_i(thread_mode), .proc_stack_i(proc_stack),
        .r0_i(r0), .r1_i(r1), .r2_i(r2), .r3_i(r3), .r12_i(r12),
        .lr_i(lr), .pc_i(pc), .psr_i(psr), .sp_i(sp), .fpr_i(fpr), .fpscr_i(fpscr),
        .wr_valid_o(wr_valid), .wr_addr_o(wr_addr), .wr_data_o(wr_data), .wr_ready_i(wr_ready),
        .rd_valid_o(rd_valid), .rd_addr_o(rd_addr), .rd_ready_i(rd_ready), .rd_data_i(rd_data),
        .busy_o(busy), .done_o(done), .sp_o(sp_out), .lr_o(lr_out), .pc_o(pc_out), .psr_o(psr_out)
    );

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Monitor: drives ready for the coming edge and scores handshakes
    always @(negedge clk) begin
        cyc++;
        wr_ready = (stall_mode == 0) || (cyc % 3 == 2);
        rd_ready = (stall_mode == 0) || (cyc % 4 == 3);
        if (wr_valid && wr_ready) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R3 unexpected stack write", {wr_addr, wr_data}, 64'h0);
            end else begin
                logic [63:0] e;
                e = exp_q.pop_front();
                check({wr_addr, wr_data} == e, "R3/R4 stack word", {wr_addr, wr_data}, e);
            end
        end
        if (rd_valid && rd_ready) begin
            check(rd_addr == exp_vaddr, "R8 vector address", rd_addr, exp_vaddr);
            check(exp_q.size() == 0, "R8 fetch after last write", exp_q.size(), 0);
        end
    end

    task automatic run_entry(input int seed, input logic [7:0] vec, input logic fpa,
                             input logic thr, input logic psp, input logic [31:0] sp_val,
                             input logic [31:0] vbase, input int stall, input bit inject);
        logic [31:0] nsp, tok, exp_pc, exp_psr;
        int words;
        int waited;
        stall_mode = stall;
        r0 = 32'h1000_0000 + seed; r1 = 32'h1100_0000 + seed; r2 = 32'h1200_0000 + seed;
        r3 = 32'h1300_0000 + seed; r12 = 32'h1C00_0000 + seed; lr = 32'h0800_1234 + seed;
        pc = 32'h0000_4000 + 4 * seed; psr = 32'h6100_0000 + 32'(seed);
        fpscr = 32'h0300_0000 + seed;
        for (int k = 0; k < FP_REGS; k++) fpr[k*32 +: 32] = 32'hF000_0000 + 32'(seed * 256 + k);
        // Driver: expected frame into the scoreboard
        words = fpa ? 26 : 8;
        nsp = sp_val - (fpa ? 32'd104 : 32'd32);
        for (int i = 0; i < words; i++) begin
            logic [31:0] w;
            case (i)
                0: w = r0; 1: w = r1; 2: w = r2; 3: w = r3;
                4: w = r12; 5: w = lr; 6: w = pc; 7: w = psr;
                24: w = fpscr; 25: w = 32'h0;
                default: w = fpr[(i-8)*32 +: 32];
            endcase
            exp_q.push_back({nsp + 32'(4*i), w});
        end
        tok = {27'h7FF_FFFF, ~fpa, thr, thr & psp, 1'b0, 1'b1};
        exp_vaddr = vbase + {22'h0, vec, 2'b00};
        exp_pc = {exp_vaddr[15:0], 16'hC0DE};
        exp_psr = {psr[31:8], vec};

        @(negedge clk);
        entry_req = 1'b1; vec_num = vec; vec_base = vbase;
        fp_active = fpa; thread_mode = thr; proc_stack = psp; sp = sp_val;
        @(negedge clk);
        entry_req = 1'b0;
        for (int i = 0; i < 3; i++) begin
            check(busy && !wr_valid && !rd_valid, "R2 wait for retire", {busy, wr_valid, rd_valid}, 3'b100);
            @(negedge clk);
        end
        retire = 1'b1;
        @(negedge clk);
        retire = 1'b0;
        if (inject) begin
            entry_req = 1'b1; vec_num = vec ^ 8'h55;
            @(negedge clk);
            entry_req = 1'b0; vec_num = vec;
        end
        waited = 0;
        while (!done && waited < 3000) begin
            @(negedge clk);
            waited++;
        end
        check(done == 1'b1, "R9 done seen", done, 1);
        check(sp_out == nsp, "R3/R4 new stack pointer", sp_out, nsp);
        check(lr_out == tok, "R6 return token", lr_out, tok);
        check(psr_out == exp_psr, inject ? "R10 vector kept" : "R7 status word", psr_out, exp_psr);
        check(pc_out == exp_pc, "R8 handler address", pc_out, exp_pc);
        check(exp_q.size() == 0, "R3/R4 frame length", exp_q.size(), 0);
        exp_q.delete();
        @(negedge clk);
        check(done == 1'b0, "R9 single-cycle done", done, 0);
        check(sp_out == nsp && pc_out == exp_pc, "R9 outputs hold", pc_out, exp_pc);
        if (inject) begin
            for (int i = 0; i < 5; i++) begin
                check(!busy && !wr_valid, "R10 no second entry", {busy, wr_valid}, 2'b00);
                @(negedge clk);
            end
        end
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(!busy && !done && !wr_valid && !rd_valid, "R1 reset controls",
              {busy, done, wr_valid, rd_valid}, 4'b0000);
        check(sp_out == 0 && lr_out == 0 && pc_out == 0 && psr_out == 0, "R1 reset outputs",
              pc_out, 0);
        rst_n = 1'b1;
        @(negedge clk);
        // handler mode, process-stack flag must not leak into bit 2
        run_entry(1, 8'd16, 1'b0, 1'b0, 1'b1, 32'h2000_8000, 32'h0000_0000, 0, 1'b0);
        // thread mode on main stack, stalled memory
        run_entry(2, 8'd42, 1'b0, 1'b1, 1'b0, 32'h2000_7F00, 32'h0000_0400, 1, 1'b0);
        // FP frame, thread mode on process stack, stalled
        run_entry(3, 8'd58, 1'b1, 1'b1, 1'b1, 32'h2000_6000, 32'h0001_0000, 1, 1'b0);
        // FP frame, handler mode, request injected while busy (R10)
        run_entry(4, 8'd99, 1'b1, 1'b0, 1'b0, 32'h2000_5000, 32'h0000_0200, 0, 1'b1);
        // vector 0, thread mode process stack
        run_entry(5, 8'd0, 1'b0, 1'b1, 1'b1, 32'h2000_4010, 32'h0000_0800, 0, 1'b0);
        // vector 255, stalled, injected request (R10)
        run_entry(6, 8'd255, 1'b0, 1'b0, 1'b0, 32'h2000_3000, 32'h1000_0000, 1, 1'b1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule